// File: doc/BRIEF.md
# Management Data Clock Prescaler

This block derives the serial clock for a shared MII management bus from the system bus clock. Software writes a divisor into a small 32-bit register through a plain write/read port. The block drops the divisor's lowest bit and raises any result below four to four, so it always produces an even division ratio of at least four. A half-period counter then toggles the output clock with a 50% duty cycle.

A downstream management frame engine can use the output clock itself. It can also use a pair of one-cycle strobes that mark the rising and falling edges of that clock, so it can shift data in the system clock domain. A divisor written while the clock runs is held back until the next falling edge of the output. Every output period therefore runs with a single ratio and produces no shortened pulse.

Top module: `mdc_prescaler`

## Requirements
- R1: A write stores bits 7:0 of the write data, and the read data returns those eight bits unchanged, including bit 0, in bits 7:0.
- R2: While reset is asserted the output clock and both edge strobes are low and the read data is zero. After reset the output runs at the system clock divided by 4.
- R3: A stored divisor of 0, 1, 2 or 3 gives an output period of 4 system clock cycles.
- R4: A stored even divisor N from 4 to 254 gives an output period of N system clock cycles.
- R5: An odd stored divisor N gives the period of N-1: bit 0 does not take part in the ratio.
- R6: Each output period has its high time equal to its low time, each lasting half the period.
- R7: A new divisor takes effect only at a falling edge of the output clock. The current high and low phases finish with the old ratio. A write that lands on the same clock edge as a falling edge waits one further period.
- R8: The rise strobe is high for exactly the first system clock cycle in which the output is high. The fall strobe is high for exactly the first cycle in which it is low after having been high. Neither strobe is high at any other time.
- R9: Write data bits 31:8 are ignored, and read data bits 31:8 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 32 | Register write data, divisor in bits 7:0 |
| rd_data_o | output | 32 | Register read data |
| mdc_o | output | 1 | Divided management clock |
| mdc_rise_o | output | 1 | One-cycle strobe at each rising edge of mdc_o |
| mdc_fall_o | output | 1 | One-cycle strobe at each falling edge of mdc_o |

## Verification
The two functions that can meet in one cycle are a register write and the period-boundary reload of the half-period length, since both happen at the edge where the output falls. The bench counts cycles from an observed rise strobe so that the write commits on exactly that edge. It then requires the low and high phases that follow to keep the old length, and the period after them to use the new one. A second directed case writes in the middle of a high phase. It checks that this high phase still ends with the old length and that the next low phase already uses the new one.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } mdc_level_e;

   function automatic bit ratio_ok(int unsigned ratio, int unsigned div_w);
      return (ratio >= 2) && (ratio % 2 == 0) && (ratio < (1 << div_w));
   endfunction

endpackage

// File: rtl/mdc_div_reg.sv
module mdc_div_reg #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [DIV_W-1:0] wr_div_i,
   output logic [DIV_W-1:0] div_o
);

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (wr_en_i) begin
         div_q <= wr_div_i;
      end
   end

   assign div_o = div_q;

   // R1: a write is visible on the stored value at the next cycle
   assert_write_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (div_o == $past(wr_div_i)));

endmodule

// File: rtl/mdc_ratio.sv
module mdc_ratio #(
   parameter int DIV_W     = 8,
   parameter int MIN_RATIO = 4,
   localparam int HALF_W   = DIV_W - 1
) (
   input  logic [HALF_W-1:0] raw_half_i,
   output logic [HALF_W-1:0] half_o
);

   localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(MIN_RATIO / 2);

   generate
      if (MIN_RATIO == 2) begin : g_floor_one
         assign half_o = (raw_half_i == '0) ? MIN_HALF : raw_half_i;
      end else begin : g_floor_cmp
         assign half_o = (raw_half_i < MIN_HALF) ? MIN_HALF : raw_half_i;
      end
   endgenerate

   always_comb begin
      assert_half_floor_R3: assert (half_o >= MIN_HALF);
   end

endmodule

// File: rtl/mdc_clk_gen.sv
module mdc_clk_gen
   import mdc_pkg::*;
#(
   parameter int HALF_W        = 7,
   parameter int MIN_HALF      = 2,
   parameter bit EDGE_PULSE_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [HALF_W-1:0] half_next_i,
   output logic              mdc_o,
   output logic              rise_o,
   output logic              fall_o
);

   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] half_cur_q;
   mdc_level_e        level_q;
   logic              rise_q;
   logic              fall_q;
   logic              phase_end;

   assign phase_end = (cnt_q == (half_cur_q - HALF_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         half_cur_q <= HALF_W'(MIN_HALF);
         level_q    <= LVL_LOW;
         rise_q     <= 1'b0;
         fall_q     <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (phase_end) begin
            cnt_q <= '0;
            if (level_q == LVL_HIGH) begin
               level_q    <= LVL_LOW;
               half_cur_q <= half_next_i;
               fall_q     <= 1'b1;
            end else begin
               level_q <= LVL_HIGH;
               rise_q  <= 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + HALF_W'(1);
         end
      end
   end

   assign mdc_o = (level_q == LVL_HIGH);

   generate
      if (EDGE_PULSE_EN) begin : g_strobes
         assign rise_o = rise_q;
         assign fall_o = fall_q;

         // R8: every rising output edge comes with its strobe
         assert_rise_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(mdc_o) |-> rise_o);
         // R8: every falling output edge comes with its strobe
         assert_fall_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(mdc_o) |-> fall_o);
      end else begin : g_no_strobes
         logic unused_strobes;
         assign unused_strobes = rise_q ^ fall_q;
         assign rise_o = 1'b0;
         assign fall_o = 1'b0;
      end
   endgenerate

   // R6: counter never reaches the phase length in force
   assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < half_cur_q);

   // R7: phase length changes only where the output has just fallen
   assert_reload_at_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(half_cur_q) |-> (!mdc_o && $past(mdc_o)));

   // R3: phase length never drops under the floor
   assert_half_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      half_cur_q >= HALF_W'(MIN_HALF));

endmodule

// File: rtl/mdc_prescaler.sv
module mdc_prescaler
   import mdc_pkg::*;
#(
   parameter int DIV_W         = 8,
   parameter int BUS_W         = 32,
   parameter int MIN_RATIO     = 4,
   parameter bit EDGE_PULSE_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [BUS_W-1:0] wr_data_i,
   output logic [BUS_W-1:0] rd_data_o,
   output logic             mdc_o,
   output logic             mdc_rise_o,
   output logic             mdc_fall_o
);

   localparam int HALF_W   = DIV_W - 1;
   localparam int MIN_HALF = MIN_RATIO / 2;

   generate
      if (DIV_W < 2) begin : g_bad_div_w
         $error("mdc_prescaler: DIV_W must be at least 2");
      end
      if (BUS_W <= DIV_W) begin : g_bad_bus_w
         $error("mdc_prescaler: BUS_W must exceed DIV_W");
      end
      if (!ratio_ok(MIN_RATIO, DIV_W)) begin : g_bad_ratio
         $error("mdc_prescaler: MIN_RATIO must be even, at least 2 and fit DIV_W");
      end
   endgenerate

   logic [DIV_W-1:0]  div_q;
   logic [HALF_W-1:0] half_next;
   logic              unused_wr_hi;

   assign unused_wr_hi = ^wr_data_i[BUS_W-1:DIV_W];

   mdc_div_reg #(
      .DIV_W (DIV_W)
   ) u_div_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_div_i (wr_data_i[DIV_W-1:0]),
      .div_o    (div_q)
   );

   mdc_ratio #(
      .DIV_W     (DIV_W),
      .MIN_RATIO (MIN_RATIO)
   ) u_ratio (
      .raw_half_i (div_q[DIV_W-1:1]),
      .half_o     (half_next)
   );

   mdc_clk_gen #(
      .HALF_W        (HALF_W),
      .MIN_HALF      (MIN_HALF),
      .EDGE_PULSE_EN (EDGE_PULSE_EN)
   ) u_clk_gen (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .half_next_i (half_next),
      .mdc_o       (mdc_o),
      .rise_o      (mdc_rise_o),
      .fall_o      (mdc_fall_o)
   );

   assign rd_data_o = {{(BUS_W - DIV_W){1'b0}}, div_q};

   // R9: upper read bits stay clear whatever is written
   assert_rd_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (rd_data_o[BUS_W-1:DIV_W] == '0));

endmodule

// File: tb/mdc_prescaler_tb_top.sv
module mdc_prescaler_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        mdc, rise, fall;

   int checks = 0;
   int fails = 0;
   int pulse_err = 0;
   int edges = 0;
   logic prev_mdc = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mdc_prescaler dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .rd_data_o  (rd_data),
      .mdc_o      (mdc),
      .mdc_rise_o (rise),
      .mdc_fall_o (fall)
   );

   // R8 monitor: strobes must mark exactly the observed output edges
   always @(negedge clk) begin
      if (rise !== (mdc && !prev_mdc) || fall !== (!mdc && prev_mdc)) pulse_err++;
      if (mdc !== prev_mdc) edges++;
      prev_mdc <= mdc;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_half(input int d);
      int e;
      e = d & 32'hFE;
      if (e < 4) e = 4;
      return e / 2;
   endfunction

   task automatic write_reg(input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_fall();
      logic p;
      p = mdc;
      forever begin
         @(negedge clk);
         if (p && !mdc) break;
         p = mdc;
      end
   endtask

   task automatic wait_rise();
      forever begin
         @(negedge clk);
         if (rise) break;
      end
   endtask

   task automatic count_level(input logic lvl, output int n);
      n = 1;
      forever begin
         @(negedge clk);
         if (mdc !== lvl) break;
         n++;
      end
   endtask

   task automatic measure(output int lo, output int hi);
      wait_fall();
      count_level(1'b0, lo);
      count_level(1'b1, hi);
   endtask

   task automatic run_div(input logic [31:0] v, input string req);
      int lo, hi, h;
      h = exp_half(int'(v[7:0]));
      write_reg(v);
      check(rd_data == {24'h0, v[7:0]}, "R1", int'(rd_data), int'(v[7:0]));
      wait_fall();
      measure(lo, hi);
      check(lo == h, req, lo, h);
      check(hi == h, "R6", hi, h);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      int lo, hi, lo2, hi2;
      int unsigned seed;
      seed = $urandom(32'd1234);

      // R2 reset state
      repeat (5) @(negedge clk);
      check(mdc == 1'b0, "R2", int'(mdc), 0);
      check(rise == 1'b0 && fall == 1'b0, "R2", int'(rise | fall), 0);
      check(rd_data == 32'h0, "R2", int'(rd_data), 0);
      rst_n = 1'b1;

      // R2 ratio after reset is 4
      measure(lo, hi);
      check(lo == 2 && hi == 2, "R2", lo + hi, 4);

      // R3 clamp
      run_div(32'd0, "R3");
      run_div(32'd1, "R3");
      run_div(32'd2, "R3");
      run_div(32'd3, "R3");
      // R4 even ratios
      run_div(32'd4, "R4");
      run_div(32'd6, "R4");
      run_div(32'd100, "R4");
      run_div(32'd254, "R4");
      // R5 odd values act as next lower even
      run_div(32'd5, "R5");
      run_div(32'd7, "R5");
      run_div(32'd255, "R5");

      // R9 upper write bits ignored
      run_div(32'hABCD_1234, "R9");
      check(rd_data[31:8] == 24'h0, "R9", int'(rd_data[31:8]), 0);

      // R7 write in the middle of a high phase
      run_div(32'd40, "R7");
      wait_rise();
      wr_en = 1'b1;
      wr_data = 32'd8;
      @(negedge clk);
      wr_en = 1'b0;
      hi = 2;
      forever begin
         @(negedge clk);
         if (!mdc) break;
         hi++;
      end
      check(hi == 20, "R7", hi, 20);
      count_level(1'b0, lo);
      check(lo == 4, "R7", lo, 4);

      // R7 write landing on the falling edge: old ratio kept one more period
      measure(lo, hi);
      check(lo == 4 && hi == 4, "R7", lo + hi, 8);
      wait_rise();
      repeat (3) @(negedge clk);
      wr_en = 1'b1;
      wr_data = 32'd60;
      @(negedge clk);
      wr_en = 1'b0;
      check(mdc == 1'b0 && fall == 1'b1, "R7", int'(mdc), 0);
      count_level(1'b0, lo);
      count_level(1'b1, hi);
      check(lo == 4 && hi == 4, "R7", lo + hi, 8);
      count_level(1'b0, lo2);
      count_level(1'b1, hi2);
      check(lo2 == 30 && hi2 == 30, "R7", lo2 + hi2, 60);

      // Random divisors with random upper bits (R1, R3, R4, R5, R6, R9)
      for (int i = 0; i < 25; i++) begin
         logic [31:0] v;
         v = $urandom();
         run_div(v, "R4");
      end

      // R8 strobe summary
      check(pulse_err == 0, "R8", pulse_err, 0);
      check(edges > 100, "R8", edges, 101);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule